// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is a slave on a two-wire serial bus that takes commands for a digitally controlled potentiometer. It runs on a system clock. It oversamples the bus clock and data lines and controls the data line as an open-drain pad through an output-enable: when enabled, the pad pulls the line low.

A command opens with an identification byte and an instruction byte. The identification byte carries a fixed type code and three bits that must match strap pins. The instruction byte carries an opcode and a pointer to one of four data registers. Transfer commands end after these two bytes. Read and write commands add two data bytes. The block does not hold the registers itself. It reads from an external register bank and, when a complete command is ended by a stop, it sends that bank a single-cycle command strobe.

While the bank reports a nonvolatile store in progress, the block does not acknowledge its address. A master can therefore poll by repeating a start and the address until the block acknowledges.

Top module: `potcmd_slave`

## Requirements
- R1: A start (data line falling while the clock line is high) seen in any state restarts address reception from bit zero. A command sent after a byte abandoned part-way completes normally.
- R2: The first byte is acknowledged only when its bits 7:4 equal 0101 and its bits 3:1 equal `strap_addr`. Bit 0 is the read/write flag.
- R3: While `nv_busy` is high, the first byte is not acknowledged even when it matches. The same byte is acknowledged once `nv_busy` has fallen.
- R4: The second byte holds the opcode in bits 7:5 and the register pointer in bits 3:2. Bits 4, 1 and 0 must be zero. Opcodes: 100 read wiper, 101 write wiper, 011 read data register, 110 write data register, 010 data register to wiper, 111 wiper to data register. Any other opcode, or a nonzero reserved bit, is not acknowledged and the block returns to idle.
- R5: The read/write flag must be 1 for the two read opcodes and 0 for the other four. On a mismatch the instruction byte is not acknowledged.
- R6: A write command has two data bytes, and each is acknowledged. In the first data byte, bits 1:0 carry value bits 9:8 and bits 7:2 are ignored. The second data byte carries bits 7:0. The strobe reports `cmd_op` 0 for a wiper write and 1 for a data-register write, with `cmd_data` set to the value.
- R7: A transfer command is two bytes long. Its strobe reports `cmd_op` 2 for data register to wiper and 3 for wiper to data register, with `cmd_ptr` set to the pointer.
- R8: A read command returns two bytes. The first carries six zero bits and then value bits 9:8, and the second carries bits 7:0. Each bit changes only after a clock fall. If the master does not acknowledge a byte, the block releases the data line until the next start or stop.
- R9: `cmd_stb` is a single-cycle pulse. It is raised only after a stop that follows a complete write or transfer command. A stop in the middle of a command, or after a read, raises no strobe.
- R10: After reset, `sda_oe` and `cmd_stb` are low.
- R11: `sda_oe` changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as sampled at the pad |
| sda_i | input | 1 | Bus data line as sampled at the pad |
| sda_oe | output | 1 | Pulls the data line low when high |
| strap_addr | input | 3 | Strap pins compared with bits 3:1 of the first byte |
| nv_busy | input | 1 | Register bank is storing; address is refused |
| rd_src_wiper | output | 1 | Read source: 1 wiper, 0 data register at `cmd_ptr` |
| rd_data | input | DATA_W (10) | Value returned by the register bank for the read source |
| cmd_stb | output | 1 | Single-cycle command strobe to the register bank |
| cmd_op | output | 2 | Command kind: 0 write wiper, 1 write data register, 2 data register to wiper, 3 wiper to data register |
| cmd_ptr | output | 2 | Data register pointer from the instruction byte |
| cmd_data | output | DATA_W (10) | Value written by a write command |

## Verification
The bench builds the block with a three-stage synchroniser instead of the default two. This lengthens the delay from a clock edge to the data-line response, so the acknowledge and read-bit timing is tested with less margin before the next clock edge. The data width stays at ten bits, which makes the first data byte carry exactly two value bits and six padding bits, so the padding and masking rules can be tested. The strap pins are tied to 101, a value with both ones and zeros, so a single flipped address bit is caught. A register-bank model in the bench holds the store-busy flag high for several thousand cycles, long enough that acknowledge polling must go around more than once.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_INSTR, S_IACK, S_WR, S_WACK, S_RD, S_RACK, S_WAIT
  } st_t;

  typedef enum logic [2:0] {
    K_RD_WIPER, K_WR_WIPER, K_RD_DREG, K_WR_DREG, K_DR2W, K_W2DR, K_BAD
  } kind_t;

  typedef enum logic [1:0] {
    C_WR_WIPER = 2'd0,
    C_WR_DREG  = 2'd1,
    C_DR2W     = 2'd2,
    C_W2DR     = 2'd3
  } cmd_t;

  // opcode field of the instruction byte -> command kind
  function automatic kind_t kind_of(input logic [2:0] code);
    case (code)
      3'b100:  return K_RD_WIPER;
      3'b101:  return K_WR_WIPER;
      3'b011:  return K_RD_DREG;
      3'b110:  return K_WR_DREG;
      3'b010:  return K_DR2W;
      3'b111:  return K_W2DR;
      default: return K_BAD;
    endcase
  endfunction

  function automatic logic kind_is_read(input kind_t k);
    return (k == K_RD_WIPER) || (k == K_RD_DREG);
  endfunction

  function automatic logic kind_is_write(input kind_t k);
    return (k == K_WR_WIPER) || (k == K_WR_DREG);
  endfunction

  function automatic cmd_t cmd_of(input kind_t k);
    case (k)
      K_WR_DREG: return C_WR_DREG;
      K_DR2W:    return C_DR2W;
      K_W2DR:    return C_W2DR;
      default:   return C_WR_WIPER;
    endcase
  endfunction

endpackage

// File: rtl/potcmd_busev.sv
module potcmd_busev #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_ch, sda_ch;
  logic         scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[MSB-1:0], scl_i};
      sda_ch <= {sda_ch[MSB-1:0], sda_i};
      scl_d  <= scl_ch[MSB];
      sda_d  <= sda_ch[MSB];
    end
  end

  assign scl_s    = scl_ch[MSB];
  assign sda_s    = sda_ch[MSB];
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_ev  = scl_s & ~scl_d;
  assign fall_ev  = ~scl_s & scl_d;

endmodule

// File: rtl/potcmd_hdr.sv
module potcmd_hdr
  import potcmd_pkg::*;
#(
  parameter logic [3:0] TYPE_ID = 4'b0101
) (
  input  logic [6:0] addr_field,
  input  logic [2:0] strap,
  input  logic       busy,
  input  logic [7:0] instr_byte,
  input  logic       rw,
  output logic       addr_ok,
  output logic       instr_ok,
  output kind_t      kind
);
  assign addr_ok  = (addr_field[6:3] == TYPE_ID) && (addr_field[2:0] == strap) && !busy;
  assign kind     = kind_of(instr_byte[7:5]);
  assign instr_ok = (kind != K_BAD) && !instr_byte[4] && (instr_byte[1:0] == 2'b00)
                    && (rw == kind_is_read(kind));
endmodule

// File: rtl/potcmd_slave.sv
module potcmd_slave
  import potcmd_pkg::*;
#(
  parameter int         DATA_W      = 10,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_ID     = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_addr,
  input  logic              nv_busy,
  output logic              rd_src_wiper,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_stb,
  output logic [1:0]        cmd_op,
  output logic [1:0]        cmd_ptr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int HI_W = DATA_W - 8;

  logic scl_s, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
  logic addr_ok, instr_ok;
  kind_t kind_w;

  st_t               st_q;
  logic [3:0]        bit_cnt;
  logic [7:0]        sh_q, tx_q;
  logic              rw_q, lo_q, pend_q, mack_q, stb_q;
  kind_t             kind_q;
  logic [1:0]        ptr_q;
  logic [DATA_W-1:0] data_q;

  potcmd_busev #(.SYNC_STAGES(SYNC_STAGES)) u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  potcmd_hdr #(.TYPE_ID(TYPE_ID)) u_hdr (
    .addr_field(sh_q[7:1]), .strap(strap_addr), .busy(nv_busy),
    .instr_byte(sh_q), .rw(rw_q),
    .addr_ok(addr_ok), .instr_ok(instr_ok), .kind(kind_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      bit_cnt <= '0;
      sh_q    <= '0;
      tx_q    <= '1;
      rw_q    <= 1'b0;
      lo_q    <= 1'b0;
      pend_q  <= 1'b0;
      mack_q  <= 1'b0;
      stb_q   <= 1'b0;
      kind_q  <= K_BAD;
      ptr_q   <= '0;
      data_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start_ev) begin
        st_q    <= S_ADDR;
        bit_cnt <= '0;
        pend_q  <= 1'b0;
        lo_q    <= 1'b0;
      end else if (stop_ev) begin
        stb_q  <= pend_q;
        pend_q <= 1'b0;
        st_q   <= S_IDLE;
      end else begin
        case (st_q)
          S_ADDR, S_INSTR, S_WR: begin
            if (rise_ev && bit_cnt != 4'd8) begin
              sh_q    <= {sh_q[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (fall_ev && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              case (st_q)
                S_ADDR: begin
                  if (addr_ok) begin st_q <= S_AACK; rw_q <= sh_q[0]; end
                  else st_q <= S_IDLE;
                end
                S_INSTR: begin
                  if (instr_ok) begin st_q <= S_IACK; kind_q <= kind_w; ptr_q <= sh_q[3:2]; end
                  else st_q <= S_IDLE;
                end
                default: begin
                  st_q <= S_WACK;
                  if (!lo_q) data_q[DATA_W-1:8] <= sh_q[HI_W-1:0];
                  else       data_q[7:0]        <= sh_q;
                end
              endcase
            end
          end
          S_AACK: if (fall_ev) st_q <= S_INSTR;
          S_IACK: if (fall_ev) begin
            lo_q <= 1'b0;
            if (kind_is_read(kind_q)) begin
              data_q <= rd_data;
              tx_q   <= {{(8-HI_W){1'b0}}, rd_data[DATA_W-1:8]};
              st_q   <= S_RD;
            end else if (kind_is_write(kind_q)) begin
              st_q <= S_WR;
            end else begin
              st_q   <= S_WAIT;
              pend_q <= 1'b1;
            end
          end
          S_WACK: if (fall_ev) begin
            if (!lo_q) begin lo_q <= 1'b1; st_q <= S_WR; end
            else begin st_q <= S_WAIT; pend_q <= 1'b1; end
          end
          S_RD: begin
            if (rise_ev) bit_cnt <= bit_cnt + 4'd1;
            if (fall_ev) begin
              if (bit_cnt == 4'd8) begin st_q <= S_RACK; bit_cnt <= '0; end
              else tx_q <= {tx_q[6:0], 1'b1};
            end
          end
          S_RACK: begin
            if (rise_ev) mack_q <= ~sda_s;
            if (fall_ev) begin
              if (mack_q && !lo_q) begin
                lo_q <= 1'b1;
                tx_q <= data_q[7:0];
                st_q <= S_RD;
              end else st_q <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe       = (st_q inside {S_AACK, S_IACK, S_WACK}) || (st_q == S_RD && !tx_q[7]);
  assign rd_src_wiper = (kind_q == K_RD_WIPER);
  assign cmd_stb      = stb_q;
  assign cmd_op       = cmd_of(kind_q);
  assign cmd_ptr      = ptr_q;
  assign cmd_data     = data_q;

  // R11: the pad enable moves only in the low phase of the bus clock
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R9: one-cycle strobe, and only after a stop
  assert_stb_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  assert_stb_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(stop_ev));
  // R3: no address acknowledge decided while the bank was busy
  assert_busy_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_AACK && $past(st_q) == S_ADDR) |-> !$past(nv_busy));
  // R1: a start always restarts address reception
  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st_q == S_ADDR && bit_cnt == 4'd0));
  // R8: padding bits of the first read byte are driven low
  assert_rd_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD && !lo_q && bit_cnt < 4'd6) |-> sda_oe);

endmodule

// File: tb/tb_potcmd_slave.sv
module tb_potcmd_slave;
  localparam int       Q     = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int       BUSY  = 3000;
  // {after_store, opcode, pointer, value}
  localparam logic [15:0] VEC [10] = '{
    {1'b0, 3'b101, 2'd0, 10'h2A5},
    {1'b0, 3'b100, 2'd0, 10'h2A5},
    {1'b0, 3'b110, 2'd2, 10'h155},
    {1'b1, 3'b011, 2'd2, 10'h155},
    {1'b0, 3'b010, 2'd2, 10'h000},
    {1'b0, 3'b100, 2'd0, 10'h155},
    {1'b0, 3'b101, 2'd0, 10'h3FF},
    {1'b0, 3'b111, 2'd1, 10'h000},
    {1'b1, 3'b011, 2'd1, 10'h3FF},
    {1'b0, 3'b011, 2'd0, 10'h0C3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, nv_busy, rd_src_wiper, cmd_stb;
  logic [1:0] cmd_op, cmd_ptr;
  logic [9:0] cmd_data, rd_data;
  logic sda_bus;
  int n_chk = 0, n_fail = 0, stb_cnt = 0, viol = 0, busy_cnt = 0;
  logic [1:0] last_op, last_ptr;
  logic [9:0] last_data;
  logic [9:0] wiper;
  logic [9:0] dr [4];
  logic oe_prev = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  potcmd_slave #(.DATA_W(10), .SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_addr(STRAP), .nv_busy(nv_busy), .rd_src_wiper(rd_src_wiper),
    .rd_data(rd_data), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_ptr(cmd_ptr),
    .cmd_data(cmd_data)
  );

  // register bank model
  assign nv_busy = (busy_cnt != 0);
  assign rd_data = rd_src_wiper ? wiper : dr[cmd_ptr];
  always @(posedge clk) begin
    if (!rst_n) begin
      wiper <= '0; dr[0] <= 10'h0C3; dr[1] <= '0; dr[2] <= '0; dr[3] <= '0; busy_cnt <= 0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (cmd_stb) begin
        case (cmd_op)
          2'd0: wiper <= cmd_data;
          2'd1: begin dr[cmd_ptr] <= cmd_data; busy_cnt <= BUSY; end
          2'd2: wiper <= dr[cmd_ptr];
          default: begin dr[cmd_ptr] <= wiper; busy_cnt <= BUSY; end
        endcase
      end
    end
  end

  // strobe and pad-timing monitor
  always @(negedge clk) begin
    if (cmd_stb) begin stb_cnt++; last_op = cmd_op; last_ptr = cmd_ptr; last_data = cmd_data; end
    if (rst_n && sda_oe != oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input logic c, input string tag, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q_wait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait(1); scl_m = 1'b1; q_wait(1);
    sda_m = 1'b0; q_wait(1); scl_m = 1'b0; q_wait(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait(1); scl_m = 1'b1; q_wait(1); sda_m = 1'b1; q_wait(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q_wait(1); scl_m = 1'b1; q_wait(2); scl_m = 1'b0; q_wait(1);
    end
    sda_m = 1'b1; q_wait(1); scl_m = 1'b1; q_wait(1);
    ack = ~sda_bus;
    q_wait(1); scl_m = 1'b0; q_wait(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q_wait(1); scl_m = 1'b1; q_wait(1); b[i] = sda_bus; q_wait(1); scl_m = 1'b0;
    end
    sda_m = ~mack; q_wait(1); scl_m = 1'b1; q_wait(2); scl_m = 1'b0; q_wait(1);
    sda_m = 1'b1;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [1:0] ptr, input logic [9:0] wd,
                         output logic [9:0] rd, output logic [7:0] hb, output int polls,
                         output logic ok);
    logic a, rw;
    logic [7:0] lb;
    rw = (op == 3'b100) || (op == 3'b011);
    polls = 0; ok = 1'b1; rd = '0; hb = '0; a = 1'b0;
    while (!a && polls < 60) begin
      bus_start();
      send_byte({4'b0101, STRAP, rw}, a);
      if (!a) begin bus_stop(); polls++; end
    end
    ok = a;
    send_byte({op, 1'b0, ptr, 2'b00}, a); ok &= a;
    if (rw) begin
      recv_byte(hb, 1'b1); recv_byte(lb, 1'b0); rd = {hb[1:0], lb};
    end else if (op == 3'b101 || op == 3'b110) begin
      send_byte({6'b101101, wd[9:8]}, a); ok &= a;
      send_byte(wd[7:0], a); ok &= a;
    end
    bus_stop();
  endtask

  function automatic string tag_of(input logic [2:0] op);
    if (op == 3'b100 || op == 3'b011) return "R8";
    if (op == 3'b101 || op == 3'b110) return "R6";
    return "R7";
  endfunction

  function automatic logic [1:0] exp_op(input logic [2:0] op);
    case (op)
      3'b101:  return 2'd0;
      3'b110:  return 2'd1;
      3'b010:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] rd;
    logic [7:0] hb, lb;
    logic [15:0] v;
    logic ok, a;
    int polls, pre;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 oe", sda_oe, 0);
    chk(cmd_stb == 1'b0, "R10 stb", cmd_stb, 0);

    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      pre = stb_cnt;
      run_cmd(v[14:12], v[11:10], v[9:0], rd, hb, polls, ok);
      chk(ok, tag_of(v[14:12]), ok, 1);
      if (v[15]) chk(polls > 0, "R3 poll", polls, 1);
      else       chk(polls == 0, "R2 ack", polls, 0);
      if (v[14:12] == 3'b100 || v[14:12] == 3'b011) begin
        chk(rd == v[9:0], "R8 value", rd, v[9:0]);
        chk(hb[7:2] == 6'd0, "R8 pad", hb, hb & 8'h03);
        chk(stb_cnt == pre, "R9 read", stb_cnt - pre, 0);
      end else begin
        chk(stb_cnt == pre + 1, "R9 count", stb_cnt - pre, 1);
        chk(last_op == exp_op(v[14:12]), tag_of(v[14:12]), last_op, exp_op(v[14:12]));
        chk(last_ptr == v[11:10], "R7 ptr", last_ptr, v[11:10]);
        if (v[14:12] == 3'b101 || v[14:12] == 3'b110)
          chk(last_data == v[9:0], "R6 data", last_data, v[9:0]);
      end
    end

    // R2: wrong type code and wrong strap
    bus_start(); send_byte({4'b0110, STRAP, 1'b0}, a); bus_stop();
    chk(!a, "R2 type", a, 0);
    bus_start(); send_byte({4'b0101, STRAP ^ 3'b001, 1'b0}, a); bus_stop();
    chk(!a, "R2 strap", a, 0);

    // R4: unknown opcode and reserved bit
    pre = stb_cnt;
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, a); send_byte(8'b000_0_00_00, a); bus_stop();
    chk(!a, "R4 opcode", a, 0);
    chk(stb_cnt == pre, "R4 no strobe", stb_cnt - pre, 0);
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, a); send_byte(8'b101_1_00_00, a); bus_stop();
    chk(!a, "R4 reserved", a, 0);

    // R5: read opcode with write flag
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, a); send_byte(8'b100_0_00_00, a); bus_stop();
    chk(!a, "R5 rw", a, 0);

    // R9: stop after only one data byte
    pre = stb_cnt;
    bus_start(); send_byte({4'b0101, STRAP, 1'b0}, a); send_byte(8'b101_0_00_00, a);
    send_byte(8'h01, a); bus_stop();
    chk(stb_cnt == pre, "R9 partial", stb_cnt - pre, 0);
    run_cmd(3'b100, 2'd0, 10'h0, rd, hb, polls, ok);
    chk(rd == 10'h3FF, "R9 wiper kept", rd, 10'h3FF);

    // R1: start in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; q_wait(1); scl_m = 1'b1; q_wait(2); scl_m = 1'b0; q_wait(1);
    end
    run_cmd(3'b101, 2'd0, 10'h0F0, rd, hb, polls, ok);
    chk(ok, "R1 restart ack", ok, 1);
    run_cmd(3'b100, 2'd0, 10'h0, rd, hb, polls, ok);
    chk(rd == 10'h0F0, "R1 restart value", rd, 10'h0F0);

    // R8: master withholds acknowledge after first byte
    bus_start(); send_byte({4'b0101, STRAP, 1'b1}, a); send_byte(8'b100_0_00_00, a);
    recv_byte(hb, 1'b0);
    recv_byte(lb, 1'b1);
    bus_stop();
    chk(lb == 8'hFF, "R8 release", lb, 8'hFF);

    chk(viol == 0, "R11 oe timing", viol, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule